// File: doc/BRIEF.md
# Lane Marker Row Encoder

This block turns one received 66-bit PCS lane alignment marker into a single 64-bit row of a 513-bit transcoded block. It removes the two-bit sync header and builds a typed row: a header byte that carries the row-follows flag, the marker's slot among the eight grouped 66-bit words and a fixed control type code. After the header byte come the three lane-number bytes and the ingress BIP3 byte of the marker, then the PCS BIP-8 error mask, the OTN BIP-8 byte and a constant 0xFF pad byte.

The caller supplies the marker word with its slot index, the flag that says whether more control rows follow below, and the two BIP-8 bytes, which are computed elsewhere. Both sides use a valid/ready handshake, and the output row is registered with one cycle of latency. With each row the block presents a contribution to the 513-bit block's F flag, and this contribution is always set. A word whose sync header is wrong is consumed without producing a row, and a one-cycle error pulse is raised in its place.

Top module: `lmr_row_encoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `row_valid` and `sync_err` are 0, `row_flag_f` is 0 and `in_ready` is 1.
- R2: A marker is valid only when `mk_word[0]` is 1 and `mk_word[1]` is 0, that is `mk_word[1:0] == 2'b01`. A valid word accepted on a clock edge (`in_valid` and `in_ready` both high) makes `row_valid` 1 after that edge.
- R3: A word with any other sync header value that is accepted produces no row. `row_valid` is 0 after that edge and `sync_err` is 1 for exactly the following cycle. `sync_err` is 1 only after such an acceptance and is never high together with `row_valid`.
- R4: The row's header byte is `row_data[7:0]`. Bit 0 is `more_rows`, bits 3:1 are `mk_pos` (bit 1 is the least significant bit), and bits 7:4 are the type code 0100 in transmission order from bit 4 to bit 7, so `row_data[7:4] == 4'b0010`.
- R5: `row_data[15:8]`, `[23:16]` and `[31:24]` hold lane bytes M0, M1 and M2, taken from `mk_word[9:2]`, `[17:10]` and `[25:18]`. `row_data[39:32]` holds the ingress BIP3 byte from `mk_word[33:26]`. `mk_word[65:34]` is discarded.
- R6: `row_data[47:40]` is `pcs_err_mask`, `row_data[55:48]` is `otn_bip`, and `row_data[63:56]` is 8'hFF.
- R7: `row_flag_f` is 1 whenever `row_valid` is 1 and 0 otherwise, which forces the 513-bit F flag for a block that holds a marker row.
- R8: `in_ready` equals `!row_valid || row_ready`. While `row_valid` is 1 and `row_ready` is 0, `row_valid` and `row_data` stay unchanged.
- R9: The latency is one cycle and the throughput one row per cycle when `row_ready` stays high. A row taken with no new acceptance leaves `row_valid` 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can accept a word this cycle |
| mk_word | input | 66 | Received marker; sync header in bits 1:0 |
| mk_pos | input | 3 | Slot index 0 to 7 within the group of eight words |
| more_rows | input | 1 | Further control rows follow below this row |
| pcs_err_mask | input | 8 | PCS BIP-8 error mask byte |
| otn_bip | input | 8 | OTN BIP-8 byte |
| row_valid | output | 1 | Output row is present |
| row_ready | input | 1 | Consumer takes the row this cycle |
| row_data | output | 64 | Transcoded row, byte n at bits 8n+7:8n |
| row_flag_f | output | 1 | F flag contribution for the 513-bit block |
| sync_err | output | 1 | One-cycle pulse after a bad sync header is consumed |

## Verification
The hardest case to reach is a bad sync header that arrives in the same cycle the consumer drains a held row. In that cycle the register must drop the old row and raise the error pulse together. A row held under back-pressure must also stay untouched while new words wait at the input. The random stimulus mixes bad headers with frequent low `row_ready` cycles so that both cases occur many times, and directed steps force each bad header value and the extreme slot and flag values.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    localparam int BYTE_W     = 8;
    localparam int ROW_BYTES  = 8;
    localparam int ROW_W      = BYTE_W * ROW_BYTES;
    localparam int SH_W       = 2;
    localparam int WORD_W     = ROW_W + SH_W;
    localparam int POS_W      = 3;
    localparam int TYPE_W     = BYTE_W - POS_W - 1;
    localparam int KEEP_BYTES = 4;

    localparam logic [SH_W-1:0]   SYNC_MARK  = 2'b01;
    localparam logic [TYPE_W-1:0] MARK_TYPE  = 4'b0010;
    localparam logic [BYTE_W-1:0] PAD_BYTE   = 8'hFF;

    typedef struct packed {
        logic [TYPE_W-1:0] cb_type;
        logic [POS_W-1:0]  pos;
        logic              fc;
    } row_hdr_t;

    function automatic logic sync_is_marker(input logic [SH_W-1:0] sh);
        return sh == SYNC_MARK;
    endfunction

    function automatic row_hdr_t build_hdr(input logic fc, input logic [POS_W-1:0] pos);
        row_hdr_t h;
        h.cb_type = MARK_TYPE;
        h.pos     = pos;
        h.fc      = fc;
        return h;
    endfunction

endpackage

// File: rtl/lmr_parse.sv
module lmr_parse
    import lmr_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_BYTE_W = BYTE_W,
    parameter int P_KEEP   = KEEP_BYTES,
    parameter int P_SH_W   = SH_W
) (
    input  logic [P_WORD_W-1:0]          word,
    output logic                         sync_ok,
    output logic [P_KEEP*P_BYTE_W-1:0]   keep
);
    localparam int KEEP_TOP = P_SH_W + P_KEEP * P_BYTE_W;

    logic unused_tail;

    assign sync_ok     = sync_is_marker(word[P_SH_W-1:0]);
    assign unused_tail = ^word[P_WORD_W-1:KEEP_TOP];

    for (genvar g = 0; g < P_KEEP; g++) begin : g_keep
        assign keep[g*P_BYTE_W +: P_BYTE_W] = word[P_SH_W + g*P_BYTE_W +: P_BYTE_W];
    end

endmodule

// File: rtl/lmr_pack.sv
module lmr_pack
    import lmr_pkg::*;
#(
    parameter int P_BYTE_W = BYTE_W,
    parameter int P_KEEP   = KEEP_BYTES,
    parameter int P_POS_W  = POS_W,
    parameter int P_ROW_W  = ROW_W
) (
    input  logic                        fc,
    input  logic [P_POS_W-1:0]          pos,
    input  logic [P_KEEP*P_BYTE_W-1:0]  keep,
    input  logic [P_BYTE_W-1:0]         err_mask,
    input  logic [P_BYTE_W-1:0]         otn_byte,
    output logic [P_ROW_W-1:0]          row,
    output logic                        f_contrib
);
    row_hdr_t hdr;

    assign hdr       = build_hdr(fc, pos);
    assign row       = {PAD_BYTE, otn_byte, err_mask, keep, hdr};
    assign f_contrib = 1'b1;

endmodule

// File: rtl/lmr_outreg.sv
module lmr_outreg #(
    parameter int P_W = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           in_good,
    input  logic [P_W-1:0] in_data,
    input  logic           in_f,
    output logic           in_ready,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [P_W-1:0] out_data,
    output logic           out_f,
    output logic           err
);
    logic take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_f     <= 1'b0;
            err       <= 1'b0;
            out_data  <= '0;
        end else begin
            err <= take && !in_good;
            if (take && in_good) begin
                out_valid <= 1'b1;
                out_f     <= in_f;
                out_data  <= in_data;
            end else if (take || out_ready) begin
                out_valid <= 1'b0;
                out_f     <= 1'b0;
            end
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_err_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(err && out_valid));

    p_drain_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !in_valid |=> !out_valid);

endmodule

// File: rtl/lmr_row_encoder.sv
module lmr_row_encoder
    import lmr_pkg::*;
#(
    parameter int P_BYTE_W = BYTE_W,
    parameter int P_POS_W  = POS_W,
    parameter int P_KEEP   = KEEP_BYTES,
    parameter int P_SH_W   = SH_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [P_SH_W+8*P_BYTE_W-1:0] mk_word,
    input  logic [P_POS_W-1:0]          mk_pos,
    input  logic                        more_rows,
    input  logic [P_BYTE_W-1:0]         pcs_err_mask,
    input  logic [P_BYTE_W-1:0]         otn_bip,
    output logic                        row_valid,
    input  logic                        row_ready,
    output logic [8*P_BYTE_W-1:0]       row_data,
    output logic                        row_flag_f,
    output logic                        sync_err
);
    localparam int L_ROW_W  = 8 * P_BYTE_W;
    localparam int L_WORD_W = L_ROW_W + P_SH_W;

    logic                       sync_ok;
    logic [P_KEEP*P_BYTE_W-1:0] keep;
    logic [L_ROW_W-1:0]         row_next;
    logic                       f_next;

    lmr_parse #(
        .P_WORD_W (L_WORD_W),
        .P_BYTE_W (P_BYTE_W),
        .P_KEEP   (P_KEEP),
        .P_SH_W   (P_SH_W)
    ) u_parse (
        .word    (mk_word),
        .sync_ok (sync_ok),
        .keep    (keep)
    );

    lmr_pack #(
        .P_BYTE_W (P_BYTE_W),
        .P_KEEP   (P_KEEP),
        .P_POS_W  (P_POS_W),
        .P_ROW_W  (L_ROW_W)
    ) u_pack (
        .fc        (more_rows),
        .pos       (mk_pos),
        .keep      (keep),
        .err_mask  (pcs_err_mask),
        .otn_byte  (otn_bip),
        .row       (row_next),
        .f_contrib (f_next)
    );

    lmr_outreg #(
        .P_W (L_ROW_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_good   (sync_ok),
        .in_data   (row_next),
        .in_f      (f_next),
        .in_ready  (in_ready),
        .out_valid (row_valid),
        .out_ready (row_ready),
        .out_data  (row_data),
        .out_f     (row_flag_f),
        .err       (sync_err)
    );

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && mk_word[1:0] == 2'b01 |=> row_valid);

    p_err_cause_r3: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> $past(in_valid && in_ready && mk_word[1:0] != 2'b01));

    p_type_r4: assert property (@(posedge clk) disable iff (rst)
        row_valid |-> row_data[7:4] == 4'b0010);

    p_pad_r6: assert property (@(posedge clk) disable iff (rst)
        row_valid |-> row_data[L_ROW_W-1 -: P_BYTE_W] == '1);

    p_flag_r7: assert property (@(posedge clk) disable iff (rst)
        row_valid |-> row_flag_f);

endmodule

// File: tb/tb_lmr_row_encoder.sv
module tb_lmr_row_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [65:0] mk_word;
    logic [2:0]  mk_pos;
    logic        more_rows;
    logic [7:0]  pcs_err_mask;
    logic [7:0]  otn_bip;
    logic        row_valid;
    logic        row_ready;
    logic [63:0] row_data;
    logic        row_flag_f;
    logic        sync_err;

    int checks = 0;
    int fails  = 0;

    logic        m_valid;
    logic        m_err;
    logic [63:0] m_row;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmr_row_encoder dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .mk_word      (mk_word),
        .mk_pos       (mk_pos),
        .more_rows    (more_rows),
        .pcs_err_mask (pcs_err_mask),
        .otn_bip      (otn_bip),
        .row_valid    (row_valid),
        .row_ready    (row_ready),
        .row_data     (row_data),
        .row_flag_f   (row_flag_f),
        .sync_err     (sync_err)
    );

    function automatic logic [63:0] expect_row(input logic [65:0] w, input logic [2:0] p,
                                               input logic fc, input logic [7:0] mask,
                                               input logic [7:0] otn);
        logic [7:0] hdr;
        hdr = {4'b0010, p, fc};
        return {8'hFF, otn, mask, w[33:26], w[25:18], w[17:10], w[9:2], hdr};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(row_valid == m_valid, "R2/R9 row_valid", 64'(row_valid), 64'(m_valid));
        chk(sync_err == m_err, "R3 sync_err", 64'(sync_err), 64'(m_err));
        chk(row_flag_f == m_valid, "R7 row_flag_f", 64'(row_flag_f), 64'(m_valid));
        if (m_valid) begin
            chk(row_data[7:0] == m_row[7:0], "R4 header byte",
                64'(row_data[7:0]), 64'(m_row[7:0]));
            chk(row_data[39:8] == m_row[39:8], "R5 lane bytes",
                64'(row_data[39:8]), 64'(m_row[39:8]));
            chk(row_data[63:40] == m_row[63:40], "R6 tail bytes",
                64'(row_data[63:40]), 64'(m_row[63:40]));
        end
    endtask

    // Called at a falling edge: drive, predict, advance one cycle, compare.
    task automatic cycle(input logic iv, input logic [65:0] w, input logic [2:0] p,
                         input logic fc, input logic [7:0] mask, input logic [7:0] otn,
                         input logic ordy);
        logic exp_rdy, acc, good;
        logic n_valid, n_err;
        logic [63:0] n_row;
        in_valid     = iv;
        mk_word      = w;
        mk_pos       = p;
        more_rows    = fc;
        pcs_err_mask = mask;
        otn_bip      = otn;
        row_ready    = ordy;
        #1;
        exp_rdy = !m_valid || ordy;
        chk(in_ready == exp_rdy, "R8 in_ready", 64'(in_ready), 64'(exp_rdy));
        acc   = iv && exp_rdy;
        good  = (w[1:0] == 2'b01);
        n_row = m_row;
        n_err = 1'b0;
        if (acc && good) begin
            n_valid = 1'b1;
            n_row   = expect_row(w, p, fc, mask, otn);
        end else if (acc) begin
            n_valid = 1'b0;
            n_err   = 1'b1;
        end else begin
            n_valid = m_valid && !ordy;
        end
        @(negedge clk);
        m_valid = n_valid;
        m_err   = n_err;
        m_row   = n_row;
        check_outputs();
    endtask

    function automatic logic [65:0] rand_word(input logic [1:0] sh);
        logic [65:0] w;
        w = {$urandom(), $urandom(), $urandom()};
        w[1:0] = sh;
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1;
        in_valid = 1'b0; mk_word = '0; mk_pos = '0; more_rows = 1'b0;
        pcs_err_mask = '0; otn_bip = '0; row_ready = 1'b0;
        m_valid = 1'b0; m_err = 1'b0; m_row = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(row_valid == 1'b0, "R1 row_valid", 64'(row_valid), 64'd0);
        chk(sync_err == 1'b0, "R1 sync_err", 64'(sync_err), 64'd0);
        chk(row_flag_f == 1'b0, "R1 row_flag_f", 64'(row_flag_f), 64'd0);
        chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
        rst = 1'b0;

        // R4 corners: slot 0 and 7, row-follows flag both ways
        cycle(1'b1, rand_word(2'b01), 3'd0, 1'b0, 8'h00, 8'h00, 1'b1);
        cycle(1'b1, rand_word(2'b01), 3'd7, 1'b1, 8'hA5, 8'h5A, 1'b1);
        cycle(1'b1, rand_word(2'b01), 3'd5, 1'b0, 8'hFF, 8'h01, 1'b1);
        // R3: each bad header value, including right after a row
        cycle(1'b1, rand_word(2'b00), 3'd1, 1'b1, 8'h11, 8'h22, 1'b1);
        cycle(1'b1, rand_word(2'b11), 3'd2, 1'b0, 8'h33, 8'h44, 1'b1);
        cycle(1'b1, rand_word(2'b10), 3'd3, 1'b1, 8'h55, 8'h66, 1'b1);
        cycle(1'b0, '0, 3'd0, 1'b0, 8'h00, 8'h00, 1'b1);
        // R8: hold under back-pressure with a waiting input
        cycle(1'b1, rand_word(2'b01), 3'd4, 1'b1, 8'h77, 8'h88, 1'b0);
        cycle(1'b1, rand_word(2'b01), 3'd6, 1'b0, 8'h99, 8'hAA, 1'b0);
        cycle(1'b1, rand_word(2'b00), 3'd6, 1'b0, 8'h99, 8'hAA, 1'b0);
        // R3 with drain in the same cycle
        cycle(1'b1, rand_word(2'b11), 3'd6, 1'b0, 8'h99, 8'hAA, 1'b1);
        // R9: drain with no new word
        cycle(1'b1, rand_word(2'b01), 3'd2, 1'b1, 8'h12, 8'h34, 1'b1);
        cycle(1'b0, '0, 3'd0, 1'b0, 8'h00, 8'h00, 1'b1);

        for (int i = 0; i < N_RANDOM; i++) begin
            logic [1:0] sh;
            sh = ($urandom_range(3, 0) != 0) ? 2'b01 : 2'($urandom_range(3, 0));
            cycle($urandom_range(3, 0) != 0, rand_word(sh), 3'($urandom_range(7, 0)),
                  1'($urandom_range(1, 0)), 8'($urandom()), 8'($urandom()),
                  $urandom_range(2, 0) != 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule